// File: doc/BRIEF.md
# One-Cycle-Control PFC Pulse-Width Modulator

This block sets the switch duty cycle of a fixed-frequency boost power-factor-correction stage. It uses the resettable-integrator method, so no input-line sensing is needed. A digitized voltage-loop error word sets the slope of an integrator. That integrator is cleared at the start of every switching cycle and then climbs by the error word on each clock. The gate stays on while the integrator is below a level derived from the averaged inductor current. The resulting on-time fraction is (Vm − k·Iavg)/Vm, with k = 50/16 ≈ 3.1.

A period counter provides the sawtooth timebase. Its rise is slow, one step per clock, and its return is a single clock. The current sample takes two paths. One is a first-order ripple filter that feeds the duty law. The other is a raw comparison against a peak limit, which cuts the gate inside the cycle except during a leading-edge blanking window. A supervisor enable can stop the gate at any time. After re-enable, the gate stays idle until the next cycle start.

Top module: `occ_pfc_pwm`

## Requirements
- R1: A switching cycle lasts `period` clocks, or MIN_PER (16) clocks when `period` is below that. `cyc_start` is high for exactly the first clock of every cycle.
- R2: A new `period` value is taken only at a cycle boundary. The cycle already running keeps its length.
- R3: With Vm > 0, num = max(Vm − floor(50·Iavg/16), 0), and Vm and Iavg captured at the cycle boundary, the gate is high for the first min(ceil(num·P/Vm), P−1−floor(P/32)) clocks of the cycle, where P is the cycle length.
- R4: When Vm is zero, or when floor(50·Iavg/16) ≥ Vm, the gate stays low for the whole cycle and no division takes place.
- R5: Duty is clamped so that the last 1+floor(P/32) clocks of every cycle are always low. For P=100 that means at most 96 high clocks.
- R6: The duty law uses Iavg, a filter of the raw sample: acc ← acc − floor(acc/8) + sample, and Iavg = floor(acc/8). A step from 0 to X applied two clocks before a boundary gives Iavg = floor(X/8) for that cycle.
- R7: Outside the blanking window, the gate is low in the same clock in which the raw sample exceeds PEAK_LIM. The gate returns in the same clock in which the sample is no longer above the limit, if the duty law still allows it. The blanking window covers the first BLANK_CYC (19) clocks of the cycle.
- R8: With `en` low, the gate is low in the same clock. After `en` returns high mid-cycle, the gate stays low until the next cycle start, and then follows R3 again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| en | input | 1 | Gate enable from the supervisor |
| vm | input | W | Voltage-loop error word (unsigned) |
| isample | input | W | Inductor current magnitude sample (unsigned) |
| period | input | PW | Switching period in clocks |
| gate | output | 1 | Switch gate command |
| cyc_start | output | 1 | High on the first clock of each cycle |

## Verification
The enable and peak-current cutoffs are combinational, so their checks sample the gate 1 ns after the input changes, in the same clock. Duty and period results register at the cycle boundary. The bench therefore waits for a `cyc_start` sample, counts gate-high samples over exactly P negative edges, and expects the next `cyc_start` on the following edge. The filter step test drives its sample at the negative edge two clocks before the boundary, so that exactly one filter update has landed when the operands are captured. After any change to period or current, the bench lets the filter settle and lets at least one full boundary pass before measuring.

// File: rtl/occ_pfc_pwm.sv
module occ_pfc_pwm #(
  parameter int W         = 12,
  parameter int PW        = 16,
  parameter int MIN_PER   = 16,
  parameter int K_NUM     = 50,
  parameter int K_SH      = 4,
  parameter int AVG_SH    = 3,
  parameter int DMAX_SH   = 5,
  parameter int BLANK_CYC = 19,
  parameter int PEAK_LIM  = 3000
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic [W-1:0]  vm,
  input  logic [W-1:0]  isample,
  input  logic [PW-1:0] period,
  output logic          gate,
  output logic          cyc_start
);
  localparam int KW = W + 6;
  localparam int RW = W + PW;
  localparam int AW = W + AVG_SH;

  logic [PW-1:0] cnt, per_q;
  logic [RW-1:0] ramp, lim_q;
  logic [W-1:0]  vm_q;
  logic [AW-1:0] acc;
  logic          armed;

  wire [W-1:0]  iavg  = acc[AW-1:AVG_SH];
  wire          last  = (per_q == '0) || (cnt == per_q - 1'b1);
  wire [PW-1:0] per_c = (period < PW'(MIN_PER)) ? PW'(MIN_PER) : period;
  wire [KW-1:0] ki    = ({6'b0, iavg} * KW'(K_NUM)) >> K_SH;
  wire [KW-1:0] vmx   = {6'b0, vm};
  wire [W-1:0]  num_c = (vmx > ki) ? W'(vmx - ki) : '0;
  wire [RW-1:0] lim_c = {{PW{1'b0}}, num_c} * {{W{1'b0}}, per_c};
  wire [PW-1:0] tmax  = per_q - 1'b1 - (per_q >> DMAX_SH);
  wire          blank = cnt < PW'(BLANK_CYC);
  wire          pk_over = isample > W'(PEAK_LIM);
  wire          pwm_on  = armed && (ramp < lim_q) && (cnt < tmax);

  assign gate      = pwm_on && en && !(pk_over && !blank);
  assign cyc_start = (per_q != '0) && (cnt == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) acc <= '0;
    else        acc <= acc - (acc >> AVG_SH) + {{AVG_SH{1'b0}}, isample};
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt <= '0; per_q <= '0; ramp <= '0; lim_q <= '0; vm_q <= '0; armed <= 1'b0;
    end else if (last) begin
      cnt   <= '0;
      per_q <= per_c;
      ramp  <= '0;
      lim_q <= lim_c;
      vm_q  <= vm;
      armed <= en;
    end else begin
      cnt  <= cnt + 1'b1;
      ramp <= ramp + {{PW{1'b0}}, vm_q};
      if (!en) armed <= 1'b0;
    end
  end

  AST_CNT_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    (per_q != '0) |-> (cnt < per_q)); // R1
  AST_PERIOD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (per_q != '0 && cnt != per_q - 1'b1) |=> $stable(per_q)); // R2
  AST_ZERO_VM_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (vm_q == '0) |-> !gate); // R4
  AST_TAIL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (per_q != '0 && cnt == per_q - 1'b1) |-> !gate); // R5
  AST_EN_CUT: assert property (@(posedge clk) disable iff (!rst_n)
    !en |-> !gate); // R8
  AST_NO_MIDCYCLE_REARM: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !$past(en) && cnt != '0) |-> !gate); // R8
  AST_PEAK_CUT: assert property (@(posedge clk) disable iff (!rst_n)
    (isample > W'(PEAK_LIM) && cnt >= PW'(BLANK_CYC)) |-> !gate); // R7
endmodule

// File: tb/occ_pfc_pwm_test.sv
module occ_pfc_pwm_test;
  localparam int W = 12, PW = 16, LIM = 3000, MINP = 16, BLK = 19;

  logic clk = 0, rst_n = 0, en = 0;
  logic [W-1:0] vm = 0, isample = 0;
  logic [PW-1:0] period = 100;
  logic gate, cyc_start;
  int checks = 0, fails = 0;

  occ_pfc_pwm #(.W(W), .PW(PW), .MIN_PER(MINP), .BLANK_CYC(BLK), .PEAK_LIM(LIM)) uut (
    .clk(clk), .rst_n(rst_n), .en(en), .vm(vm), .isample(isample),
    .period(period), .gate(gate), .cyc_start(cyc_start));

  always #10 clk = ~clk;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int exp_ton(int p, int v, int i);
    int pe = (p < MINP) ? MINP : p;
    int num = v - ((i * 50) >> 4);
    int t, tm;
    if (v == 0 || num <= 0) return 0;
    t  = (num * pe + v - 1) / v;
    tm = pe - 1 - (pe >> 5);
    return (t < tm) ? t : tm;
  endfunction

  task automatic wait_start();
    do @(negedge clk); while (!cyc_start);
  endtask

  task automatic setup(input int p, input int v, input int i);
    @(negedge clk);
    period = PW'(p); vm = W'(v); isample = W'(i);
    repeat (3 * ((p < MINP) ? MINP : p) + 150) @(negedge clk);
  endtask

  task automatic measure(input int p, input int v, input int i, input string req);
    int pe = (p < MINP) ? MINP : p;
    int hi = 0;
    setup(p, v, i);
    wait_start();
    for (int k = 0; k < pe; k++) begin
      if (k > 0) @(negedge clk);
      hi += gate;
    end
    chk(hi == exp_ton(p, v, i), req, hi, exp_ton(p, v, i));
    @(negedge clk);
    chk(cyc_start == 1'b1, "R1 cycle length", cyc_start, 1);
  endtask

  task automatic t_reset();
    repeat (3) @(negedge clk);
    chk(gate == 0, "R8 reset gate", gate, 0);
    chk(cyc_start == 0, "R1 reset start", cyc_start, 0);
    rst_n = 1; en = 1;
  endtask

  task automatic t_period_change();
    int l = 1;
    setup(100, 2000, 200);
    wait_start();
    while (1) begin
      @(negedge clk);
      if (l == 1) period = 60;
      if (cyc_start) break;
      l++;
    end
    chk(l == 100, "R2 running cycle kept", l, 100);
    l = 1;
    while (1) begin
      @(negedge clk);
      if (cyc_start) break;
      l++;
    end
    chk(l == 60, "R2 new period used", l, 60);
  endtask

  task automatic t_filter_step();
    int hi = 0;
    setup(100, 2000, 0);
    wait_start();
    repeat (98) @(negedge clk);
    isample = 800;
    wait_start();
    for (int k = 0; k < 100; k++) begin
      if (k > 0) @(negedge clk);
      hi += gate;
    end
    chk(hi == exp_ton(100, 2000, 100), "R6 filtered step", hi, exp_ton(100, 2000, 100));
  endtask

  task automatic t_peak();
    setup(100, 1000, 0);
    wait_start();
    repeat (2) @(negedge clk);
    isample = 4000; #1;
    chk(gate == 1, "R7 blanked", gate, 1);
    @(negedge clk); isample = 0;
    repeat (37) @(negedge clk);
    isample = 4000; #1;
    chk(gate == 0, "R7 cut same clock", gate, 0);
    @(negedge clk); #1;
    chk(gate == 0, "R7 held while over", gate, 0);
    isample = LIM; #1;
    chk(gate == 1, "R7 released at limit", gate, 1);
  endtask

  task automatic t_enable();
    int hi = 0;
    setup(100, 2000, 200);
    wait_start();
    repeat (10) @(negedge clk);
    en = 0; #1;
    chk(gate == 0, "R8 en cut", gate, 0);
    repeat (10) @(negedge clk);
    en = 1;
    for (int k = 20; k < 100; k++) begin
      if (k > 20) @(negedge clk);
      #1 hi += gate;
    end
    chk(hi == 0, "R8 no rearm mid-cycle", hi, 0);
    @(negedge clk);
    hi = 0;
    for (int k = 0; k < 100; k++) begin
      if (k > 0) @(negedge clk);
      hi += gate;
    end
    chk(hi == exp_ton(100, 2000, 200), "R8 resumes", hi, exp_ton(100, 2000, 200));
  endtask

  initial begin
    t_reset();
    measure(100, 2000, 200, "R3 nominal");
    measure(64, 3000, 400, "R3 second pattern");
    measure(100, 1000, 0, "R5 max duty clamp");
    measure(100, 0, 200, "R4 zero vm");
    measure(100, 500, 200, "R4 current exceeds vm");
    measure(5, 2000, 200, "R1 minimum period");
    t_period_change();
    t_filter_step();
    t_peak();
    t_enable();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule